// File: doc/BRIEF.md
# IR carrier period meter

This block measures the carrier period of a raw, still-modulated infrared input. The input is asynchronous. It passes through a synchroniser, and each low-to-high transition counts as one carrier edge. Between consecutive edges the block counts a 2 MHz timebase, which gives one tick every 500 ns. At each completed period it latches the count into a one-byte status word. The host reads that word with a single-cycle read strobe. The carrier frequency in hertz is 2,000,000 divided by the period field.

Status byte layout: bit 7 is the valid flag, and bits 6:0 hold the period in 500 ns ticks. The period field means nothing when the valid flag is clear. A field of zero means no usable carrier, even when the flag is set. The tick divider and the synchroniser depth are parameters. With the default divider of 125, a 250 MHz clock gives the 500 ns tick.

Top module: `ir_period_meter`

## Requirements
- R1: After reset, a read returns 0x00.
- R2: Only low-to-high transitions of `ir_i`, seen after a two-flop synchroniser, mark carrier edges. The measured value depends only on the rise-to-rise interval and not on the high time.
- R3: The period field (bits 6:0) holds the number of 500 ns ticks (TICK_DIV clocks each) between two consecutive rising edges. An interval of exactly N ticks reads as N.
- R4: The valid flag (bit 7) sets only when a second consecutive rising edge completes a period, counted after reset or after a loss of carrier. A single edge leaves the byte unchanged.
- R5: A period longer than 127 ticks reads as 127 with the valid flag set.
- R6: If 255 ticks pass without a rising edge, the valid flag clears and the period field keeps its last value. The next edge does not set the flag again.
- R7: The latched byte changes only when a rising edge completes a period. A read does not alter it.
- R8: `rdata_o` takes the status byte on the clock edge where `rd_i` is high, and holds it otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock (TICK_DIV cycles per 500 ns) |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ir_i | input | 1 | Raw asynchronous IR input |
| rd_i | input | 1 | Read strobe, one cycle |
| rdata_o | output | 8 | Read data: {valid, period[6:0]} |

## Verification
The hardest case to reach from the ports is the re-arm rule after a loss of carrier. The input must first stay quiet for more than 255 ticks. After that, exactly one edge has to arrive and the byte must be shown to stay invalid, and only then may a second edge bring it back. The stimulus produces this by running a long saturating burst and then idling for 110 ticks after the last full period. It then sends two lone edges and reads between them. All carrier intervals are exact multiples of the tick length, so each expected count is exact whatever the phase of the divider.

// File: rtl/ir_pm_pkg.sv
package ir_pm_pkg;
  localparam int unsigned PERIOD_W = 7;
  localparam int unsigned CNT_W    = 8;

  typedef struct packed {
    logic                valid;
    logic [PERIOD_W-1:0] period;
  } ir_status_t;
endpackage

// File: rtl/ir_tick_gen.sv
module ir_tick_gen #(
  parameter int unsigned DIV = 125
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  generate
    if (DIV <= 1) begin : g_pass
      assign tick_o = 1'b1;
    end else begin : g_div
      localparam int unsigned W = $clog2(DIV);
      logic [W-1:0] cnt_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                       cnt_q <= '0;
        else if (cnt_q == W'(DIV - 1))     cnt_q <= '0;
        else                               cnt_q <= cnt_q + 1'b1;
      end
      assign tick_o = (cnt_q == W'(DIV - 1));

      p_tick_gap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/ir_sync_edge.sv
module ir_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ir_i,
  output logic rise_o
);
  // sh_q[STAGES-1] is the synchronised level, sh_q[STAGES] its previous value
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], ir_i};
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];

  p_rise_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/ir_period_cnt.sv
module ir_period_cnt
  import ir_pm_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       rise_i,
  output ir_status_t status_o
);
  localparam logic [CNT_W-1:0] CNT_LIM = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] SAT     = CNT_W'((1 << PERIOD_W) - 1);

  logic [CNT_W-1:0]    cnt_q, cnt_inc;
  logic [PERIOD_W-1:0] period_q;
  logic                valid_q, armed_q;

  // count includes a tick landing in the edge cycle, so N*DIV cycles read as N
  always_comb begin
    cnt_inc = cnt_q;
    if (tick_i && cnt_q != CNT_LIM) cnt_inc = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      period_q <= '0;
      valid_q  <= 1'b0;
      armed_q  <= 1'b0;
    end else if (rise_i) begin
      cnt_q   <= '0;
      armed_q <= 1'b1;
      if (armed_q) begin
        period_q <= (cnt_inc > SAT) ? SAT[PERIOD_W-1:0] : cnt_inc[PERIOD_W-1:0];
        valid_q  <= 1'b1;
      end
    end else begin
      cnt_q <= cnt_inc;
      if (cnt_inc == CNT_LIM) begin
        valid_q <= 1'b0;
        armed_q <= 1'b0;
      end
    end
  end

  assign status_o = '{valid: valid_q, period: period_q};

  p_valid_on_edge_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_q) |-> $past(rise_i));
  p_timeout_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(valid_q) |-> !$past(rise_i));
  p_latch_on_edge_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(period_q) |-> $past(rise_i));
endmodule

// File: rtl/ir_period_meter.sv
module ir_period_meter
  import ir_pm_pkg::*;
#(
  parameter int unsigned TICK_DIV    = 125,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ir_i,
  input  logic       rd_i,
  output logic [7:0] rdata_o
);
  logic       tick, rise;
  ir_status_t status;

  ir_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_o(tick));

  ir_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .ir_i(ir_i), .rise_o(rise));

  ir_period_cnt u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .rise_i(rise),
    .status_o(status));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (rd_i) rdata_o <= status;
  end

  p_rdata_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(rd_i) |-> $stable(rdata_o));
endmodule

// File: tb/ir_period_meter_bench.sv
module ir_period_meter_bench;
  localparam int TD = 125;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ir = 1'b0;
  logic       rd = 1'b0;
  logic [7:0] rdata;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2 clk = ~clk;

  ir_period_meter #(.TICK_DIV(TD)) u_ir_period_meter (
    .clk_i(clk), .rst_ni(rst_n), .ir_i(ir), .rd_i(rd), .rdata_o(rdata));

  // monitor: compare one cycle after each sampled strobe
  initial forever begin
    @(posedge clk);
    if (rd) begin
      @(negedge clk);
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R8: unexpected read, got %02h expected none", rdata);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_cmp++;
        if (rdata !== e) begin
          n_bad++;
          $display("FAIL %s: got %02h expected %02h", t, rdata, e);
        end
      end
    end
  end

  task automatic rd_expect(input logic [7:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
  endtask

  // n periods of `ticks`, each starting with a rise; optional read in last low phase
  task automatic burst(input int ticks, input int hi, input int n,
                       input bit chk, input logic [7:0] e, input string t);
    for (int i = 0; i < n; i++) begin
      ir = 1'b1;
      repeat (hi * TD) @(negedge clk);
      ir = 1'b0;
      if (chk && i == n - 1) begin
        rd_expect(e, t);
        repeat ((ticks - hi) * TD - 1) @(negedge clk);
      end else begin
        repeat ((ticks - hi) * TD) @(negedge clk);
      end
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    rd_expect(8'h00, "R1 reset");
    burst(56, 14, 1, 1'b1, 8'h00, "R4 single edge");
    burst(56, 14, 3, 1'b1, 8'hB8, "R3 56 ticks");
    burst(56, 40, 2, 1'b1, 8'hB8, "R2 duty change");
    burst(36, 18, 1, 1'b1, 8'hB8, "R7 first rise of new rate");
    burst(36, 18, 3, 1'b1, 8'hA4, "R3 36 ticks");
    burst(36, 30, 2, 1'b1, 8'hA4, "R2 duty 36");
    burst(150, 75, 3, 1'b1, 8'hFF, "R5 saturate");
    repeat (110 * TD) @(negedge clk);
    rd_expect(8'h7F, "R6 timeout");
    burst(40, 20, 1, 1'b1, 8'h7F, "R6 one edge after loss");
    burst(40, 20, 1, 1'b1, 8'hA8, "R4 rearm");
    rd_expect(8'hA8, "R7 reread");
    rd_expect(8'hA8, "R8 back to back");
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule